// File: doc/BRIEF.md
# Load Effective-Address Reservation Bank

This block is a small bank of reservation stations that serves load instructions in an out-of-order core. It does not read memory. Each station holds the base-register operand of one load, a 16-bit immediate offset and the reorder-buffer slot the load was renamed to. When the base operand is known, the station's own 32-bit adder forms the effective address. The station then asks for the shared result bus and broadcasts that address under the reorder-buffer slot's tag. The reorder buffer performs the memory access later, in program order.

The issue stage writes one load per cycle into the lowest-numbered free station. A base operand may arrive already resolved, or as a 5-bit producer tag. A pending operand watches the 37-bit result bus. The upper 5 bits of the bus carry the tag and the lower 32 bits carry the value. A station frees itself in the cycle after its broadcast is granted. The bank raises a full flag when no station is free.

Top module: `lar_unit`

## Requirements
- R1: During reset and in the first cycle after it, every station is empty, `full_o` is 0 and `bcast_req_o` is 0.
- R2: An issue (`iss_valid_i`=1) fills the lowest-numbered empty station at the next clock edge. `full_o` is 1 exactly when all 6 stations are occupied. An issue presented while `full_o` is 1 is discarded and never broadcast.
- R3: The broadcast address is the base value plus the 16-bit offset sign-extended from bit 15, taken modulo 2^32. Overflow simply wraps.
- R4: The broadcast bus carries the reorder-buffer tag given at issue in bits 36:32 and the address in bits 31:0.
- R5: A pending base captures `snoop_bus_i[31:0]` at a clock edge where `snoop_valid_i`=1 and `snoop_bus_i[36:32]` equals its stored tag. Snoops with another tag are ignored, and so is any snoop that arrives after the base is resolved.
- R6: A station whose base is still pending never requests the bus.
- R7: An issue whose pending tag matches a valid snoop in the same cycle captures that value at once, so the station is ready in the next cycle.
- R8: While `bcast_req_o`=1 and `bcast_grant_i`=0, the request stays asserted and `bcast_bus_o` does not change in the next cycle, even if other stations become ready.
- R9: A station whose broadcast is granted becomes empty at that clock edge.
- R10: When no request is being held, the lowest-numbered ready station drives the bus.
- R11: A load issued with a resolved base requests the bus in the cycle after issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid_i | input | 1 | Issue a load this cycle |
| iss_base_pend_i | input | 1 | Base operand not yet produced |
| iss_base_tag_i | input | 5 | Producer tag of a pending base |
| iss_base_val_i | input | 32 | Base value when resolved |
| iss_off_i | input | 16 | Signed immediate offset |
| iss_rob_i | input | 5 | Reorder-buffer slot tag for the broadcast |
| full_o | output | 1 | No station free |
| snoop_valid_i | input | 1 | Result bus carries a value |
| snoop_bus_i | input | 37 | Result bus: tag[36:32], value[31:0] |
| bcast_req_o | output | 1 | Request for the result bus |
| bcast_grant_i | input | 1 | Result bus granted this cycle |
| bcast_bus_o | output | 37 | Outgoing broadcast: tag[36:32], address[31:0] |

## Verification
The assertions check the handshake and the occupancy on every cycle. A denied request must stay asserted with a frozen bus. A full bank stays full until a grant arrives, and a grant to a full bank frees a station. Reset leaves the bank idle. The address arithmetic, tag routing, snoop matching, same-cycle capture, lowest-index allocation and broadcast order can only be shown by the bench's scenarios. These include a sweep of base and offset values across the sign and wrap boundaries, and a fill-and-drain sequence that reuses a freed station.

// File: rtl/lar_pkg.sv
package lar_pkg;

    parameter int TAG_W  = 5;
    parameter int DATA_W = 32;
    parameter int OFF_W  = 16;
    localparam int BUS_W = TAG_W + DATA_W;

    typedef struct packed {
        logic              pend;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } opnd_t;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } bus_t;

    function automatic logic [DATA_W-1:0] sext_off(input logic [OFF_W-1:0] off);
        return {{(DATA_W-OFF_W){off[OFF_W-1]}}, off};
    endfunction

    // resolve a pending operand from a matching bus value
    function automatic opnd_t snoop_upd(input opnd_t o, input logic v, input bus_t b);
        opnd_t r;
        r = o;
        if (o.pend && v && (b.tag == o.tag)) begin
            r.pend = 1'b0;
            r.val  = b.data;
        end
        return r;
    endfunction

endpackage

// File: rtl/lar_entry.sv
module lar_entry
    import lar_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   alloc_i,
    input  opnd_t                  iss_op_i,
    input  logic [OFF_W-1:0]       iss_off_i,
    input  logic [TAG_W-1:0]       iss_rob_i,
    input  logic                   snoop_v_i,
    input  bus_t                   snoop_i,
    input  logic                   free_i,
    output logic                   busy_o,
    output logic                   ready_o,
    output bus_t                   out_o
);

    logic              busy_q;
    opnd_t             base_q;
    logic [DATA_W-1:0] off_q;
    logic [TAG_W-1:0]  rob_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            base_q <= '0;
            off_q  <= '0;
            rob_q  <= '0;
        end else if (alloc_i) begin
            busy_q <= 1'b1;
            base_q <= snoop_upd(iss_op_i, snoop_v_i, snoop_i);
            off_q  <= sext_off(iss_off_i);
            rob_q  <= iss_rob_i;
        end else begin
            if (free_i)
                busy_q <= 1'b0;
            base_q <= snoop_upd(base_q, snoop_v_i, snoop_i);
        end
    end

    assign busy_o     = busy_q;
    assign ready_o    = busy_q && !base_q.pend;
    assign out_o.tag  = rob_q;
    assign out_o.data = base_q.val + off_q;

endmodule

// File: rtl/lar_pick.sv
module lar_pick #(
    parameter int N_ENT = 6
) (
    input  logic [N_ENT-1:0] busy_i,
    input  logic             want_i,
    output logic [N_ENT-1:0] alloc_o,
    output logic             full_o
);

    logic found;

    always_comb begin
        alloc_o = '0;
        found   = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (!busy_i[i] && !found) begin
                alloc_o[i] = want_i;
                found      = 1'b1;
            end
        end
    end

    assign full_o = &busy_i;

endmodule

// File: rtl/lar_arb.sv
module lar_arb #(
    parameter int N_ENT = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_ENT-1:0] ready_i,
    input  logic             grant_i,
    output logic [N_ENT-1:0] sel_o,
    output logic             req_o
);

    logic [N_ENT-1:0] first;
    logic [N_ENT-1:0] lock_sel_q;
    logic             lock_v_q;
    logic             found;

    always_comb begin
        first = '0;
        found = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (ready_i[i] && !found) begin
                first[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    assign sel_o = lock_v_q ? lock_sel_q : first;
    assign req_o = |sel_o;

    // keep a denied choice until its grant arrives
    always_ff @(posedge clk) begin
        if (rst) begin
            lock_v_q   <= 1'b0;
            lock_sel_q <= '0;
        end else begin
            lock_v_q   <= req_o && !grant_i;
            lock_sel_q <= sel_o;
        end
    end

endmodule

// File: rtl/lar_unit.sv
module lar_unit
    import lar_pkg::*;
#(
    parameter int N_ENT = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  iss_valid_i,
    input  logic                  iss_base_pend_i,
    input  logic [TAG_W-1:0]      iss_base_tag_i,
    input  logic [DATA_W-1:0]     iss_base_val_i,
    input  logic [OFF_W-1:0]      iss_off_i,
    input  logic [TAG_W-1:0]      iss_rob_i,
    output logic                  full_o,
    input  logic                  snoop_valid_i,
    input  logic [BUS_W-1:0]      snoop_bus_i,
    output logic                  bcast_req_o,
    input  logic                  bcast_grant_i,
    output logic [BUS_W-1:0]      bcast_bus_o
);

    logic [N_ENT-1:0] busy;
    logic [N_ENT-1:0] ready;
    logic [N_ENT-1:0] alloc;
    logic [N_ENT-1:0] sel;
    logic             full;
    opnd_t            iss_op;
    bus_t             snoop;
    bus_t             ent_out [N_ENT];
    bus_t             bus_mux;

    assign iss_op.pend = iss_base_pend_i;
    assign iss_op.tag  = iss_base_tag_i;
    assign iss_op.val  = iss_base_val_i;
    assign snoop       = snoop_bus_i;

    lar_pick #(.N_ENT(N_ENT)) u_pick (
        .busy_i  (busy),
        .want_i  (iss_valid_i),
        .alloc_o (alloc),
        .full_o  (full)
    );

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        lar_entry u_ent (
            .clk       (clk),
            .rst       (rst),
            .alloc_i   (alloc[g]),
            .iss_op_i  (iss_op),
            .iss_off_i (iss_off_i),
            .iss_rob_i (iss_rob_i),
            .snoop_v_i (snoop_valid_i),
            .snoop_i   (snoop),
            .free_i    (sel[g] && bcast_grant_i),
            .busy_o    (busy[g]),
            .ready_o   (ready[g]),
            .out_o     (ent_out[g])
        );
    end

    lar_arb #(.N_ENT(N_ENT)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .ready_i (ready),
        .grant_i (bcast_grant_i),
        .sel_o   (sel),
        .req_o   (bcast_req_o)
    );

    always_comb begin
        bus_mux = '0;
        for (int i = 0; i < N_ENT; i++)
            if (sel[i])
                bus_mux = bus_mux | ent_out[i];
    end

    assign bcast_bus_o = bus_mux;
    assign full_o      = full;

endmodule

// File: rtl/lar_chk.sv
module lar_chk
    import lar_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             full_o,
    input logic             bcast_req_o,
    input logic             bcast_grant_i,
    input logic [BUS_W-1:0] bcast_bus_o
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!bcast_req_o && !full_o));

    // R8
    hold_denied_chk: assert property (@(posedge clk) disable iff (rst)
        (bcast_req_o && !bcast_grant_i) |=> (bcast_req_o && $stable(bcast_bus_o)));

    // R2
    full_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (full_o && !(bcast_req_o && bcast_grant_i)) |=> full_o);

    // R9
    grant_frees_chk: assert property (@(posedge clk) disable iff (rst)
        (full_o && bcast_req_o && bcast_grant_i) |=> !full_o);

endmodule

bind lar_unit lar_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .full_o        (full_o),
    .bcast_req_o   (bcast_req_o),
    .bcast_grant_i (bcast_grant_i),
    .bcast_bus_o   (bcast_bus_o)
);

// File: tb/lar_unit_tb.sv
`timescale 1ns/1ps
module lar_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iss_valid = 1'b0;
    logic        iss_pend = 1'b0;
    logic [4:0]  iss_tag = '0;
    logic [31:0] iss_val = '0;
    logic [15:0] iss_off = '0;
    logic [4:0]  iss_rob = '0;
    logic        full;
    logic        snp_v = 1'b0;
    logic [36:0] snp_bus = '0;
    logic        req;
    logic        grant = 1'b0;
    logic [36:0] bus;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lar_unit u_dut (
        .clk (clk), .rst (rst),
        .iss_valid_i (iss_valid), .iss_base_pend_i (iss_pend),
        .iss_base_tag_i (iss_tag), .iss_base_val_i (iss_val),
        .iss_off_i (iss_off), .iss_rob_i (iss_rob),
        .full_o (full),
        .snoop_valid_i (snp_v), .snoop_bus_i (snp_bus),
        .bcast_req_o (req), .bcast_grant_i (grant), .bcast_bus_o (bus)
    );

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic pend, input logic [4:0] tg, input logic [31:0] v,
                         input logic [15:0] off, input logic [4:0] rob);
        iss_valid = 1'b1; iss_pend = pend; iss_tag = tg;
        iss_val = v; iss_off = off; iss_rob = rob;
        tick();
        iss_valid = 1'b0;
    endtask

    task automatic grant_one();
        grant = 1'b1;
        tick();
        grant = 1'b0;
    endtask

    function automatic logic [36:0] expect_bus(input logic [4:0] rob, input logic [31:0] b,
                                               input logic [15:0] off);
        logic [31:0] a;
        a = b + {{16{off[15]}}, off};
        return {rob, a};
    endfunction

    initial begin
        #150000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] bases [6];
        logic [15:0] offs  [6];
        logic [36:0] held;
        bases = '{32'h0, 32'h1, 32'h7fff_ffff, 32'h8000_0000, 32'hffff_ffff, 32'h1234_5678};
        offs  = '{16'h0, 16'h1, 16'h7fff, 16'h8000, 16'hffff, 16'hff00};

        @(negedge clk);
        tick();
        chk("R1 req in reset", {63'd0, req}, 64'd0);
        rst = 1'b0;
        tick();
        chk("R1 full after reset", {63'd0, full}, 64'd0);
        chk("R1 req after reset", {63'd0, req}, 64'd0);

        // R3 R4 R11 R9: sweep of base and offset
        for (int b = 0; b < 6; b++) begin
            for (int o = 0; o < 6; o++) begin
                logic [4:0] rb;
                rb = 5'((b * 6 + o) % 32);
                issue(1'b0, 5'd0, bases[b], offs[o], rb);
                chk("R11 req after ready issue", {63'd0, req}, 64'd1);
                chk("R3 R4 address and tag", {27'd0, bus}, {27'd0, expect_bus(rb, bases[b], offs[o])});
                grant_one();
                chk("R9 freed after grant", {63'd0, req}, 64'd0);
            end
        end

        // R2 R10 R8: fill, reject when full, drain in index order
        for (int k = 0; k < 6; k++) begin
            chk("R2 not full yet", {63'd0, full}, 64'd0);
            issue(1'b0, 5'd0, 32'(k * 256), 16'(k), 5'(10 + k));
        end
        chk("R2 full with six", {63'd0, full}, 64'd1);
        issue(1'b0, 5'd0, 32'hdead, 16'd0, 5'd31);
        chk("R10 lowest ready first", {27'd0, bus}, {27'd0, expect_bus(5'd10, 32'd0, 16'd0)});
        held = bus;
        tick();
        tick();
        chk("R8 bus stable while denied", {27'd0, bus}, {27'd0, held});
        chk("R8 req held while denied", {63'd0, req}, 64'd1);
        grant_one();
        chk("R9 full drops after grant", {63'd0, full}, 64'd0);
        chk("R10 next index", {27'd0, bus}, {27'd0, expect_bus(5'd11, 32'd256, 16'd1)});
        issue(1'b0, 5'd0, 32'h5, 16'd0, 5'd20);
        chk("R8 held choice kept over lower index", {27'd0, bus}, {27'd0, expect_bus(5'd11, 32'd256, 16'd1)});
        chk("R2 refilled", {63'd0, full}, 64'd1);
        grant_one();
        chk("R2 freed slot reused", {27'd0, bus}, {27'd0, expect_bus(5'd20, 32'h5, 16'd0)});
        grant_one();
        for (int k = 2; k < 6; k++) begin
            chk("R10 drain order", {27'd0, bus}, {27'd0, expect_bus(5'(10 + k), 32'(k * 256), 16'(k))});
            grant_one();
        end
        chk("R2 rejected issue never broadcast", {63'd0, req}, 64'd0);
        chk("R2 empty after drain", {63'd0, full}, 64'd0);

        // R5 R6: pending base and snoop matching
        issue(1'b1, 5'd9, 32'hffff_ffff, 16'h0010, 5'd2);
        chk("R6 pending does not request", {63'd0, req}, 64'd0);
        snp_v = 1'b1; snp_bus = {5'd8, 32'h1000};
        tick();
        chk("R5 other tag ignored", {63'd0, req}, 64'd0);
        snp_bus = {5'd9, 32'h1000};
        snp_v = 1'b0;
        tick();
        chk("R5 invalid snoop ignored", {63'd0, req}, 64'd0);
        snp_v = 1'b1; snp_bus = {5'd9, 32'h2000};
        tick();
        snp_v = 1'b0;
        chk("R5 matching tag captured", {27'd0, bus}, {27'd0, expect_bus(5'd2, 32'h2000, 16'h10)});
        snp_v = 1'b1; snp_bus = {5'd9, 32'h9999};
        tick();
        snp_v = 1'b0;
        chk("R5 resolved base ignores snoop", {27'd0, bus}, {27'd0, expect_bus(5'd2, 32'h2000, 16'h10)});
        grant_one();

        // R7: capture in the issue cycle
        snp_v = 1'b1; snp_bus = {5'd3, 32'h40};
        issue(1'b1, 5'd3, 32'h0, 16'hfffc, 5'd6);
        snp_v = 1'b0;
        chk("R7 same cycle capture req", {63'd0, req}, 64'd1);
        chk("R7 same cycle capture addr", {27'd0, bus}, {27'd0, expect_bus(5'd6, 32'h40, 16'hfffc)});
        grant_one();

        // R8: denied request keeps bus while lower index wakes
        issue(1'b1, 5'd12, 32'h0, 16'd0, 5'd1);
        issue(1'b0, 5'd0, 32'h500, 16'd0, 5'd21);
        chk("R8 ready entry shown", {27'd0, bus}, {27'd0, expect_bus(5'd21, 32'h500, 16'd0)});
        snp_v = 1'b1; snp_bus = {5'd12, 32'h700};
        tick();
        snp_v = 1'b0;
        chk("R8 lock over woken lower index", {27'd0, bus}, {27'd0, expect_bus(5'd21, 32'h500, 16'd0)});
        grant_one();
        chk("R10 woken entry follows", {27'd0, bus}, {27'd0, expect_bus(5'd1, 32'h700, 16'd0)});
        grant_one();
        chk("R9 all free", {63'd0, req}, 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule